// File: doc/BRIEF.md
# Interrupt Pin Service Logic

This block turns the line levels of a set of interrupt pins into delivery requests toward the processors. Each pin has a redirection entry, supplied as input fields: a mask bit, a trigger mode (edge or level), an 8-bit vector, an 8-bit destination, a destination-mode bit and a 3-bit delivery mode. The block keeps a request bit per pin and an in-service lockout bit per pin. It picks one pending pin per cycle and raises a single delivery request, which it holds until the delivery fabric acknowledges it.

The acknowledgement says whether at least one destination took the interrupt. For a level-triggered pin that was taken, the lockout is set, and further deliveries from that pin wait. An end-of-interrupt message carries a vector and a trigger mode. A level-mode message releases the lockout of every entry programmed with that vector. If such a pin's line is still high, it is delivered again. Edge pins latch rising edges. A rising edge that arrives while an earlier one is still waiting is reported as coalesced.

Top module: `pin_service`

## Requirements
- R1: For a pin in level mode (cfg_level=1), the request bit equals the line level sampled at the previous clock edge. A low line therefore leaves nothing to deliver.
- R2: For a pin in edge mode (cfg_level=0), a rising line sets the request bit at the next edge. The bit is cleared at the edge on which that pin's delivery request is raised. A falling line does not clear it.
- R3: A rising line on an edge-mode pin whose request bit is already set makes no extra delivery. It pulses that pin's bit of `coalesced` high for one cycle, one edge later.
- R4: A pin whose mask bit is 1 is never selected for delivery, and its request bit is kept.
- R5: A level-mode pin whose lockout bit is set is not selected, while its request bit still follows the line.
- R6: When a delivery for a level-mode pin is acknowledged with `dlv_hit`=1, that pin's lockout bit is set. With `dlv_hit`=0, or for an edge-mode pin, the lockout is unchanged.
- R7: A level-mode end-of-interrupt (eoi_level=1) clears the lockout of every entry whose vector equals `eoi_vector`. A pin whose line is still high is then delivered again.
- R8: An edge-mode end-of-interrupt (eoi_level=0) leaves every lockout bit unchanged.
- R9: Among pending pins, the lowest-numbered one is served first. Only one request is outstanding. While `dlv_ack` is low, it is held with all its fields stable.
- R10: The request carries the selected entry's vector, destination, destination mode, 3-bit delivery mode and trigger mode unchanged, and `req_pin` gives its index.
- R11: If, in one cycle, a level-mode end-of-interrupt matches the vector of a level request that is acknowledged with a hit, that pin's lockout ends set.
- R12: After reset, no request is outstanding and all request, lockout and coalesce bits are 0. A request is raised on the second edge after a line change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NPINS | Interrupt line level per pin |
| cfg_mask | input | NPINS | Entry mask bit per pin |
| cfg_level | input | NPINS | Trigger mode per pin, 1 = level |
| cfg_vector | input | NPINS x 8 | Entry vector per pin |
| cfg_dest | input | NPINS x 8 | Entry destination per pin |
| cfg_dest_logical | input | NPINS | Destination mode per pin |
| cfg_dmode | input | NPINS x 3 | Delivery mode per pin |
| dlv_ack | input | 1 | Outstanding request consumed |
| dlv_hit | input | 1 | With dlv_ack: taken by at least one destination |
| eoi_valid | input | 1 | End-of-interrupt message valid |
| eoi_level | input | 1 | End-of-interrupt trigger mode, 1 = level |
| eoi_vector | input | 8 | End-of-interrupt vector |
| req_valid | output | 1 | Delivery request outstanding |
| req_pin | output | PW | Index of the pin being delivered |
| req_vector | output | 8 | Request vector |
| req_dest | output | 8 | Request destination |
| req_dest_logical | output | 1 | Request destination mode |
| req_dmode | output | 3 | Request delivery mode |
| req_level | output | 1 | Request trigger mode |
| irr_q | output | NPINS | Request bit per pin |
| remote_q | output | NPINS | Lockout bit per pin |
| coalesced | output | NPINS | One-cycle coalesce pulse per pin |

## Verification
Two events can land in the same cycle: an end-of-interrupt that releases a lockout, and the acknowledgement that sets the lockout for the same pin. The bench provokes this by asserting `dlv_ack` with `dlv_hit` and a level-mode end-of-interrupt carrying the outstanding request's vector on one edge. It judges the result by reading `remote_q` one cycle later: the bit must be set. It then confirms that the pin is not delivered again until a later end-of-interrupt releases it.

// File: rtl/pin_service.sv
module pin_service #(
  parameter int NPINS = 8,
  parameter int PW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      line_in,
  input  logic [NPINS-1:0]      cfg_mask,
  input  logic [NPINS-1:0]      cfg_level,
  input  logic [NPINS-1:0][7:0] cfg_vector,
  input  logic [NPINS-1:0][7:0] cfg_dest,
  input  logic [NPINS-1:0]      cfg_dest_logical,
  input  logic [NPINS-1:0][2:0] cfg_dmode,
  input  logic                  dlv_ack,
  input  logic                  dlv_hit,
  input  logic                  eoi_valid,
  input  logic                  eoi_level,
  input  logic [7:0]            eoi_vector,
  output logic                  req_valid,
  output logic [PW-1:0]         req_pin,
  output logic [7:0]            req_vector,
  output logic [7:0]            req_dest,
  output logic                  req_dest_logical,
  output logic [2:0]            req_dmode,
  output logic                  req_level,
  output logic [NPINS-1:0]      irr_q,
  output logic [NPINS-1:0]      remote_q,
  output logic [NPINS-1:0]      coalesced
);

  logic [NPINS-1:0] prev_q, rise, pending, eoi_hit, grant_oh, set_oh;
  logic [PW-1:0]    sel;
  logic             issue, set_rem;

  assign rise    = line_in & ~prev_q;
  assign pending = irr_q & ~cfg_mask & ~(cfg_level & remote_q);
  assign issue   = !req_valid && (|pending);
  assign set_rem = req_valid && dlv_ack && dlv_hit && req_level;

  always_comb begin
    sel = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (pending[i]) sel = PW'(i);
  end

  assign grant_oh = issue   ? (NPINS'(1) << sel)     : '0;
  assign set_oh   = set_rem ? (NPINS'(1) << req_pin) : '0;

  always_comb
    for (int i = 0; i < NPINS; i++)
      eoi_hit[i] = eoi_valid && eoi_level && (cfg_vector[i] == eoi_vector);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      irr_q     <= '0;
      remote_q  <= '0;
      coalesced <= '0;
    end else begin
      prev_q    <= line_in;
      coalesced <= rise & ~cfg_level & irr_q;
      remote_q  <= (remote_q & ~eoi_hit) | set_oh;
      for (int i = 0; i < NPINS; i++) begin
        if (cfg_level[i])      irr_q[i] <= line_in[i];
        else if (rise[i])      irr_q[i] <= 1'b1;
        else if (grant_oh[i])  irr_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid        <= 1'b0;
      req_pin          <= '0;
      req_vector       <= '0;
      req_dest         <= '0;
      req_dest_logical <= 1'b0;
      req_dmode        <= '0;
      req_level        <= 1'b0;
    end else if (req_valid) begin
      if (dlv_ack) req_valid <= 1'b0;
    end else if (issue) begin
      req_valid        <= 1'b1;
      req_pin          <= sel;
      req_vector       <= cfg_vector[sel];
      req_dest         <= cfg_dest[sel];
      req_dest_logical <= cfg_dest_logical[sel];
      req_dmode        <= cfg_dmode[sel];
      req_level        <= cfg_level[sel];
    end
  end

endmodule

// File: rtl/pin_service_sva.sv
module pin_service_sva #(
  parameter int NPINS = 8,
  parameter int PW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] line_in,
  input logic [NPINS-1:0] cfg_mask,
  input logic [NPINS-1:0] cfg_level,
  input logic             dlv_ack,
  input logic             dlv_hit,
  input logic             eoi_valid,
  input logic             eoi_level,
  input logic             req_valid,
  input logic [PW-1:0]    req_pin,
  input logic [7:0]       req_vector,
  input logic             req_level,
  input logic [NPINS-1:0] irr_q,
  input logic [NPINS-1:0] remote_q
);

  logic up_q;
  logic [NPINS-1:0] sel_oh;
  assign sel_oh = NPINS'(1) << req_pin;

  always_ff @(posedge clk)
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;

  assert_level_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |=> (((irr_q ^ $past(line_in)) & $past(cfg_level)) == '0));

  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $rose(req_valid)) |-> (($past(cfg_mask) & sel_oh) == '0));

  assert_lockout_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $rose(req_valid)) |-> (($past(remote_q) & $past(cfg_level) & sel_oh) == '0));

  assert_hit_sets_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && req_valid && dlv_ack && dlv_hit && req_level) |=> ((remote_q & $past(sel_oh)) != '0));

  assert_edge_eoi_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && eoi_valid && !eoi_level && !(req_valid && dlv_ack && dlv_hit && req_level))
      |=> $stable(remote_q));

  assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && req_valid && !dlv_ack) |=> (req_valid && $stable(req_pin) && $stable(req_vector)));

endmodule

bind pin_service pin_service_sva #(.NPINS(NPINS), .PW(PW)) u_sva (.*);

// File: tb/pin_service_bench.sv
module pin_service_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int PW = 3;

  typedef struct packed {
    logic [7:0] pins;
    logic       ack, hit, ev, el;
    logic [7:0] evec;
    logic       x_valid;
    logic [2:0] x_pin;
    logic [7:0] x_irr, x_rem, x_coal;
  } step_t;

  // pin0 edge, pin1/pin3 level, pin2 masked edge; vector = 0x20 + pin
  localparam step_t TBL [20] = '{
    '{8'h01,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h01,8'h00,8'h00}, // R2 R12 edge latch
    '{8'h01,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd0,8'h00,8'h00,8'h00}, // R2 cleared on issue
    '{8'h01,1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h00,8'h00,8'h00}, // R6 edge no lock
    '{8'h0A,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h0A,8'h00,8'h00}, // R1
    '{8'h0A,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd1,8'h0A,8'h00,8'h00}, // R9 lowest first
    '{8'h0A,1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h0A,8'h02,8'h00}, // R6 lock set
    '{8'h0A,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd3,8'h0A,8'h02,8'h00}, // R5 pin1 locked
    '{8'h0A,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h0A,8'h02,8'h00}, // R6 no hit
    '{8'h0A,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd3,8'h0A,8'h02,8'h00}, // R6 retried
    '{8'h0A,1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h0A,8'h0A,8'h00}, // R6
    '{8'h0A,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h0A,8'h0A,8'h00}, // R5 both locked
    '{8'h0A,1'b0,1'b0,1'b1,1'b0,8'h21, 1'b0,3'd0,8'h0A,8'h0A,8'h00}, // R8
    '{8'h0A,1'b0,1'b0,1'b1,1'b1,8'h21, 1'b0,3'd0,8'h0A,8'h08,8'h00}, // R7 release
    '{8'h0A,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1,3'd1,8'h0A,8'h08,8'h00}, // R7 redeliver
    '{8'h0A,1'b1,1'b1,1'b1,1'b1,8'h21, 1'b0,3'd0,8'h0A,8'h0A,8'h00}, // R11
    '{8'h04,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h04,8'h0A,8'h00}, // R1 R4
    '{8'h04,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h04,8'h0A,8'h00}, // R4 kept
    '{8'h04,1'b0,1'b0,1'b1,1'b1,8'h23, 1'b0,3'd0,8'h04,8'h02,8'h00}, // R7
    '{8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h04,8'h02,8'h00}, // R2 low keeps
    '{8'h04,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,3'd0,8'h04,8'h02,8'h04}  // R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] line_in = '0, cfg_mask, cfg_level, cfg_dest_logical;
  logic [N-1:0][7:0] cfg_vector, cfg_dest;
  logic [N-1:0][2:0] cfg_dmode;
  logic dlv_ack = 1'b0, dlv_hit = 1'b0, eoi_valid = 1'b0, eoi_level = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic req_valid, req_dest_logical, req_level;
  logic [PW-1:0] req_pin;
  logic [7:0] req_vector, req_dest;
  logic [2:0] req_dmode;
  logic [N-1:0] irr_q, remote_q, coalesced;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_service #(.NPINS(N)) u_pin_service (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic base_cfg();
    cfg_mask  = 8'b1111_0100;
    cfg_level = 8'b0000_1010;
    for (int i = 0; i < N; i++) begin
      cfg_vector[i]       = 8'h20 + 8'(i);
      cfg_dest[i]         = 8'h80 + 8'(i);
      cfg_dmode[i]        = 3'(i);
      cfg_dest_logical[i] = i[0];
    end
  endtask

  task automatic do_reset();
    line_in = '0; dlv_ack = 0; dlv_hit = 0; eoi_valid = 0; eoi_level = 0;
    rst_n = 0; tick(); tick(); rst_n = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    finish_run();
  end

  initial begin
    base_cfg();
    tick();
    do_reset();
    check("R12 reset valid", 32'(req_valid), 0);
    check("R12 reset irr", 32'(irr_q), 0);
    check("R12 reset remote", 32'(remote_q), 0);
    check("R12 reset coalesced", 32'(coalesced), 0);

    for (int r = 0; r < 20; r++) begin
      line_in = TBL[r].pins; dlv_ack = TBL[r].ack; dlv_hit = TBL[r].hit;
      eoi_valid = TBL[r].ev; eoi_level = TBL[r].el; eoi_vector = TBL[r].evec;
      tick();
      check($sformatf("table row %0d valid", r), 32'(req_valid), 32'(TBL[r].x_valid));
      if (TBL[r].x_valid)
        check($sformatf("table row %0d pin", r), 32'(req_pin), 32'(TBL[r].x_pin));
      check($sformatf("table row %0d irr", r), 32'(irr_q), 32'(TBL[r].x_irr));
      check($sformatf("table row %0d remote", r), 32'(remote_q), 32'(TBL[r].x_rem));
      check($sformatf("table row %0d coalesced", r), 32'(coalesced), 32'(TBL[r].x_coal));
    end
    dlv_ack = 0; dlv_hit = 0; eoi_valid = 0;

    // R9 R10: priority, field passthrough, hold
    do_reset();
    cfg_mask = 8'b1001_0100;
    line_in = 8'h60;
    tick();
    check("R12 no request one edge after line", 32'(req_valid), 0);
    tick();
    check("R9 pin5 first", 32'(req_pin), 5);
    check("R10 vector", 32'(req_vector), 32'h25);
    check("R10 dest", 32'(req_dest), 32'h85);
    check("R10 dest mode", 32'(req_dest_logical), 1);
    check("R10 delivery mode", 32'(req_dmode), 5);
    check("R10 trigger mode", 32'(req_level), 0);
    tick(); tick(); tick();
    check("R9 held valid", 32'(req_valid), 1);
    check("R9 held pin", 32'(req_pin), 5);
    dlv_ack = 1; dlv_hit = 1;
    tick();
    dlv_ack = 0; dlv_hit = 0;
    check("R9 dropped after ack", 32'(req_valid), 0);
    tick();
    check("R9 next pin6", 32'(req_pin), 6);
    check("R10 vector pin6", 32'(req_vector), 32'h26);
    dlv_ack = 1; tick(); dlv_ack = 0;

    // R7: one EOI releases every entry sharing the vector
    base_cfg();
    do_reset();
    cfg_vector[1] = 8'h40; cfg_vector[3] = 8'h40;
    line_in = 8'h0A;
    tick(); tick();
    dlv_ack = 1; dlv_hit = 1; tick(); dlv_ack = 0; dlv_hit = 0;
    tick();
    check("R9 second level pin", 32'(req_pin), 3);
    dlv_ack = 1; dlv_hit = 1; tick(); dlv_ack = 0; dlv_hit = 0;
    check("R6 both locked", 32'(remote_q), 32'h0A);
    eoi_valid = 1; eoi_level = 1; eoi_vector = 8'h40;
    tick();
    eoi_valid = 0; eoi_level = 0;
    check("R7 shared vector released", 32'(remote_q), 0);
    tick();
    check("R7 redelivery valid", 32'(req_valid), 1);
    check("R7 redelivery pin", 32'(req_pin), 1);

    finish_run();
  end
endmodule